// File: doc/BRIEF.md
# Mailbox Command Header Checker

This block sits at the entry of a command mailbox. It takes a valid/ready stream of 32-bit words. Each packet is one header word followed by the number of argument words that the header declares. The header holds a command code in bits [10:0], a reserved bit at [11] that must be zero, and an argument count in bits [22:12]. The count does not include the header. The block checks the header against the one command it supports, the image-update request with code 0x05C. It reads every declared argument word, so the stream stays on packet boundaries even when a packet is rejected. It then returns a single response header.

The response header uses the same layout as the command header. The low eleven bits carry an error code, where 0 means success, and the count field carries the response argument count, which is always 0. The image-update request takes either no arguments or a 64-bit start address. The address arrives as two words, low word first, and is taken as zero when absent. The upper word is reserved and must be zero. When a request is accepted, the block raises an execute strobe for one cycle together with the 32-bit start address. The strobe comes in the same cycle that the response header is taken downstream. Flash access and reconfiguration happen in the logic that consumes that strobe.

Top module: `cmd_hdr_checker`

## Requirements
- R1: After a header with argument count N, the block accepts exactly N further words before it presents a response, and it presents no response before the last of them.
- R2: Code 0x05C with argument count 0 returns a response word of 0x00000000. In the handshake cycle of that response, the execute strobe is high for one cycle with address 0.
- R3: Code 0x05C with argument count 2 and a zero second argument returns error 0. The execute strobe carries the first argument word as the address.
- R4: A command code other than 0x05C, compared on all eleven bits [10:0], returns error code 0x001 and no execute strobe.
- R5: Code 0x05C with an argument count other than 0 or 2 returns error code 0x002 and no execute strobe.
- R6: A header with bit [11] set but otherwise valid returns error code 0x003 and no execute strobe.
- R7: For code 0x05C with count 2, a nonzero second argument word returns error code 0x003 and no execute strobe.
- R8: When several errors apply, the unknown code (0x001) wins over the wrong count (0x002), and the wrong count wins over a reserved-bit violation (0x003).
- R9: A rejected packet still has all of its declared argument words consumed, so the next header is decoded correctly.
- R10: While a response waits for rsp_ready, in_ready is low and rsp_data holds steady.
- R11: After reset, in_ready is high and rsp_valid and exec_valid are low.
- R12: Every response word has bits [31:11] equal to zero: a response argument count of 0 and a clear reserved bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Header or argument word |
| rsp_valid | output | 1 | Response header valid |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_data | output | 32 | Response header (error code in [10:0]) |
| exec_valid | output | 1 | One-cycle execute strobe for an accepted image update |
| exec_addr | output | 32 | Image start address sent with the strobe |

## Verification
The bench sends packets whose declared count does not match what the command allows, including a three-word body. A design that trusted the command table rather than the header count would then read the next packet's header as data and return wrong codes for every later packet. Combined faults are checked against the R8 priority, because swapping the order of the error tests changes the returned code. A design that failed to clear the address from the previous packet would be caught: an image update with no address follows one that carried an address, and the strobe must come with zero. The response is also held back for several cycles while a new header waits at the input, to catch a design that drops the response or accepts input too early.

// File: rtl/cmd_hdr_checker.sv
module cmd_hdr_checker #(
  parameter int          DATA_W   = 32,
  parameter int          CODE_W   = 11,
  parameter int          LEN_W    = 11,
  parameter logic [10:0] IMG_CODE = 11'h05C,
  parameter int          IMG_ARGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              exec_valid,
  output logic [DATA_W-1:0] exec_addr
);
  localparam int RSV_BIT = CODE_W;
  localparam int LEN_LSB = CODE_W + 1;
  localparam int PAD_W   = DATA_W - LEN_LSB - LEN_W;
  localparam logic [CODE_W-1:0] E_OK   = '0;
  localparam logic [CODE_W-1:0] E_CODE = CODE_W'(1);
  localparam logic [CODE_W-1:0] E_LEN  = CODE_W'(2);
  localparam logic [CODE_W-1:0] E_RSV  = CODE_W'(3);

  typedef enum logic [1:0] {ST_HDR, ST_ARG, ST_RSP} state_t;

  state_t            state;
  logic [LEN_W-1:0]  rem;
  logic [LEN_W-1:0]  idx;
  logic [CODE_W-1:0] err;
  logic [DATA_W-1:0] addr;

  logic [CODE_W-1:0] hdr_code;
  logic [LEN_W-1:0]  hdr_len;
  logic              hdr_rsv;
  logic [CODE_W-1:0] hdr_err;
  logic              take;

  assign hdr_code = in_data[CODE_W-1:0];
  assign hdr_rsv  = in_data[RSV_BIT];
  assign hdr_len  = in_data[LEN_LSB +: LEN_W];

  always_comb begin
    if (hdr_code != IMG_CODE[CODE_W-1:0])
      hdr_err = E_CODE;
    else if (hdr_len != '0 && hdr_len != LEN_W'(IMG_ARGS))
      hdr_err = E_LEN;
    else if (hdr_rsv)
      hdr_err = E_RSV;
    else
      hdr_err = E_OK;
  end

  assign in_ready   = (state != ST_RSP);
  assign take       = in_valid && in_ready;
  assign rsp_valid  = (state == ST_RSP);
  assign rsp_data   = {{PAD_W{1'b0}}, {LEN_W{1'b0}}, 1'b0, err};
  assign exec_valid = rsp_valid && rsp_ready && (err == E_OK);
  assign exec_addr  = addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_HDR;
      rem   <= '0;
      idx   <= '0;
      err   <= E_OK;
      addr  <= '0;
    end else begin
      case (state)
        ST_HDR: if (take) begin
          err   <= hdr_err;
          addr  <= '0;
          idx   <= '0;
          rem   <= hdr_len;
          state <= (hdr_len == '0) ? ST_RSP : ST_ARG;
        end
        ST_ARG: if (take) begin
          idx <= idx + 1'b1;
          rem <= rem - 1'b1;
          if (idx == '0)
            addr <= in_data;
          if (idx == LEN_W'(1) && in_data != '0 && err == E_OK)
            err <= E_RSV;
          if (rem == LEN_W'(1))
            state <= ST_RSP;
        end
        ST_RSP: if (rsp_ready)
          state <= ST_HDR;
        default: state <= ST_HDR;
      endcase
    end
  end

  a_r10_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  a_r10_no_input_while_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !in_ready);

  a_r1_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARG) |-> (rem != '0));

  a_r2_exec_single: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |=> !exec_valid && !rsp_valid);

  a_r12_rsp_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[DATA_W-1:RSV_BIT] == '0));
endmodule

// File: tb/test_cmd_hdr_checker.sv
module test_cmd_hdr_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        exec_valid;
  logic [31:0] exec_addr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cmd_hdr_checker i_cmd_hdr_checker (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .exec_valid(exec_valid), .exec_addr(exec_addr)
  );

  localparam int NV = 12;
  localparam logic [31:0] V_HDR [NV] = '{
    32'h0000005C, 32'h0000205C, 32'h0000205C, 32'h0000005D,
    32'h0000045C, 32'h0000105C, 32'h0000305C, 32'h0000085C,
    32'h0000205C, 32'h0000185D, 32'h0000185C, 32'h0000285C};
  localparam logic [31:0] V_A0 [NV] = '{
    32'h0, 32'h12345678, 32'hFFFFFFFC, 32'h0,
    32'h0, 32'h0000AAAA, 32'h1, 32'h0,
    32'h100, 32'h7, 32'h7, 32'h10};
  localparam logic [31:0] V_A1 [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h2, 32'h0,
    32'h1, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] V_A2 [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h3, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [10:0] V_ERR [NV] = '{
    11'h0, 11'h0, 11'h0, 11'h1,
    11'h1, 11'h2, 11'h2, 11'h3,
    11'h3, 11'h1, 11'h2, 11'h3};
  localparam string V_REQ [NV] = '{
    "R2", "R3", "R3", "R4", "R4", "R5", "R5", "R6", "R7", "R8", "R8", "R8"};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic get_rsp(input logic [10:0] exp_err, input logic [31:0] exp_addr, input string req);
    int waited = 0;
    @(negedge clk);
    while (!rsp_valid && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    check(rsp_valid && rsp_data == {21'd0, exp_err}, req, rsp_data, {21'd0, exp_err});
    check(rsp_data[31:11] == '0, "R12", rsp_data, {21'd0, exp_err});
    rsp_ready = 1'b1;
    #1;
    check(exec_valid == (exp_err == 0), req, {31'd0, exec_valid}, {31'd0, exp_err == 0});
    if (exp_err == 0)
      check(exec_addr == exp_addr, req, exec_addr, exp_addr);
    @(posedge clk);
    #1 rsp_ready = 1'b0;
    check(!exec_valid && !rsp_valid, "R2", {30'd0, exec_valid, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: idle outputs during and after reset
    check(in_ready && !rsp_valid && !exec_valid, "R11",
          {29'd0, in_ready, rsp_valid, exec_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !rsp_valid && !exec_valid, "R11",
          {29'd0, in_ready, rsp_valid, exec_valid}, 32'h4);

    for (int v = 0; v < NV; v++) begin
      int n;
      n = int'(V_HDR[v][22:12]);
      send_word(V_HDR[v]);
      if (n > 0) begin
        @(negedge clk);
        check(!rsp_valid, "R1", {31'd0, rsp_valid}, 32'd0);
      end
      if (n > 0) send_word(V_A0[v]);
      if (n > 1) send_word(V_A1[v]);
      if (n > 2) send_word(V_A2[v]);
      get_rsp(V_ERR[v], V_A0[v], V_REQ[v]);
    end

    // R9: long rejected packet, then a good update right after it
    send_word(32'h0000507F);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!rsp_valid, "R1", {31'd0, rsp_valid}, 32'd0);
      send_word(32'h0000205C);
    end
    get_rsp(11'h1, 32'h0, "R9");
    send_word(32'h0000205C);
    send_word(32'hCAFE0000);
    send_word(32'h0);
    get_rsp(11'h0, 32'hCAFE0000, "R9");

    // R2: update without an address after one that had an address
    send_word(32'h0000005C);
    get_rsp(11'h0, 32'h0, "R2");

    // R10: stall the response with a header waiting at the input
    send_word(32'h0000085C);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h0000005C;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(rsp_valid && !in_ready && rsp_data == 32'h3, "R10",
            rsp_data, 32'h3);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
    @(posedge clk);
    #1 in_valid = 1'b0;
    get_rsp(11'h0, 32'h0, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule